// File: doc/BRIEF.md
# Region-based I/O wait-state generator

This block stretches peripheral accesses of a processor core. The core first writes one 16-bit control word into the block through a small register-write port. That word holds a 3-bit wait code for each of four I/O address regions, a 3-bit wait code for data-space accesses and one global mode bit. When the core starts an access with a one-cycle request strobe, the block takes the code for that access, turns it into a wait count and drives a ready output low for that many clocks. It then signals completion with a one-cycle done pulse.

The I/O space has 2048 locations, so the block looks only at the low 11 bits of the access address. The top two of those bits select the region. With the mode bit clear, the count equals the code. With the mode bit set, the count is twice the code plus one, which reaches up to 15 wait states. The count is latched when the request is accepted, so neither a new request nor a control-word write can disturb an access that is already running.

Top module: `io_wait_gen`

## Requirements
- R1: Region selection uses only address bits 10:0. Bits above bit 10 of `acc_addr` have no effect on the wait count.
- R2: Address bits 10:9 pick the I/O region: 0 for 0x000–0x1FF, 1 for 0x200–0x3FF, 2 for 0x400–0x5FF and 3 for 0x600–0x7FF. The code for region k is bits [3k+2:3k] of the control word.
- R3: With control-word bit 15 at 0, the number of wait cycles equals the selected 3-bit code N (0..7).
- R4: With control-word bit 15 at 1, the number of wait cycles is 2N+1 (1..15).
- R5: A request whose count is zero raises `acc_done` in the cycle after the request edge, and `acc_ready` stays high.
- R6: A request with count W>0 holds `acc_ready` low for exactly W cycles after the request edge. In the next cycle `acc_ready` is high and `acc_done` is high for one cycle.
- R7: A write with `cfg_addr` equal to 0x3FFE loads the control word. A write to any other address leaves it unchanged.
- R8: A request with `acc_io` low uses the data-space code in control-word bits 14:12 and the same mode bit.
- R9: A request strobe that arrives while an access is waiting is ignored. It neither restarts nor extends the access, and it produces no extra done pulse.
- R10: A control-word write during a waiting access does not change that access. The next access uses the new word.
- R11: After reset the control word is 0x7FFF (all codes 7, mode 0), `acc_ready` is high and `acc_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 14 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| acc_req | input | 1 | One-cycle access request strobe |
| acc_io | input | 1 | 1 = I/O-space access, 0 = data-space access |
| acc_addr | input | 14 | Access address |
| acc_ready | output | 1 | Low while wait states are being inserted |
| acc_done | output | 1 | One-cycle pulse when an access completes |

## Verification
The bench checks each region boundary and sets the high address bits on purpose. A decoder that used the wrong bit slice, or that saw the upper bits, would apply another region's code. It covers codes 0 and 7 in both modes, where an off-by-one counter would lengthen or shorten the wait by one cycle or leave out the +1 of the doubled mode. It sends a second strobe in the middle of an access and writes the control word in the middle of an access. A design that restarted the count or reloaded it from the live register would then report a wrong wait length or a second done pulse. It also writes to a neighbouring address, which a loose address compare would accept.

// File: rtl/iow_pkg.sv
package iow_pkg;

    localparam int CODE_W      = 3;
    localparam int NUM_REGIONS = 4;
    localparam int REGION_W    = $clog2(NUM_REGIONS);
    localparam int CNT_W       = CODE_W + 1;
    localparam int CTRL_W      = 1 + CODE_W + NUM_REGIONS * CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // control word: mode in MSB, data-space code, then region codes (region 0 lowest)
    typedef struct packed {
        logic                         dbl_mode;
        code_t                        dm_code;
        logic [NUM_REGIONS-1:0][CODE_W-1:0] io_code;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic done;
        cnt_t cnt;
    } seq_t;

    function automatic cnt_t wait_from_code(input code_t n, input logic dbl);
        return dbl ? {n, 1'b1} : {1'b0, n};
    endfunction

endpackage

// File: rtl/iow_ctrl_reg.sv
module iow_ctrl_reg
    import iow_pkg::*;
#(
    parameter int                 BUS_ADDR_W = 14,
    parameter int                 DATA_W     = 16,
    parameter logic [BUS_ADDR_W-1:0] CTRL_ADDR = 14'h3FFE,
    parameter logic [DATA_W-1:0]  RESET_VAL  = 16'h7FFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [BUS_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output ctrl_t                 ctrl
);

    ctrl_t ctrl_d, ctrl_q;
    logic  hit;

    always_comb begin
        hit    = we && (addr == CTRL_ADDR);
        ctrl_d = ctrl_q;
        if (hit) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= ctrl_t'(RESET_VAL[CTRL_W-1:0]);
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    // R7: a matching write lands in the register one cycle later
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CTRL_ADDR) |=> (ctrl_q == ctrl_t'($past(wdata[CTRL_W-1:0]))));

    // R7: writes elsewhere leave the word unchanged
    a_r7_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == CTRL_ADDR) |=> $stable(ctrl_q));

endmodule

// File: rtl/iow_code_sel.sv
module iow_code_sel
    import iow_pkg::*;
#(
    parameter int BUS_ADDR_W = 14,
    parameter int IO_ADDR_W  = 11
) (
    input  ctrl_t                 ctrl,
    input  logic                  is_io,
    input  logic [BUS_ADDR_W-1:0] addr,
    output code_t                 code,
    output logic [NUM_REGIONS-1:0] region_hit
);

    localparam int REG_LSB = IO_ADDR_W - REGION_W;

    logic [REGION_W-1:0] region;
    code_t               io_sel;

    assign region = addr[IO_ADDR_W-1:REG_LSB];

    for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_region
        assign region_hit[k] = is_io && (region == REGION_W'(k));
    end

    always_comb begin
        io_sel = '0;
        for (int k = 0; k < NUM_REGIONS; k++) begin
            if (region_hit[k]) io_sel = io_sel | ctrl.io_code[k];
        end
        code = is_io ? io_sel : ctrl.dm_code;
    end

    // R2: exactly one region matches on an I/O access, none on data space
    always_comb begin
        a_r2_one_region: assert (is_io ? ($countones(region_hit) == 1) : (region_hit == '0));
    end

endmodule

// File: rtl/iow_count_map.sv
module iow_count_map
    import iow_pkg::*;
(
    input  code_t code,
    input  logic  dbl_mode,
    output cnt_t  count
);

    assign count = wait_from_code(code, dbl_mode);

    // R3/R4: normal mode never exceeds the code range; doubled mode is always odd
    always_comb begin
        a_r4_odd_count: assert (!dbl_mode || count[0]);
        a_r3_short_range: assert (dbl_mode || !count[CNT_W-1]);
    end

endmodule

// File: rtl/iow_seq.sv
module iow_seq
    import iow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  cnt_t count,
    output logic ready,
    output logic done
);

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == cnt_t'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt - cnt_t'(1);
            end
        end else if (req) begin
            if (count == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.cnt  = count;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready = !s_q.busy;
    assign done  = s_q.done;

    // R6/R9: a waiting access counts down by one each cycle, whatever req does
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt > cnt_t'(1)) |=> (s_q.busy && s_q.cnt == $past(s_q.cnt) - cnt_t'(1)));

    // R6: last wait cycle is followed by ready and a done pulse
    a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt == cnt_t'(1)) |=> (!s_q.busy && s_q.done));

    // R5: zero-count request completes in the next cycle without waiting
    a_r5_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !s_q.busy && count == '0) |=> (s_q.done && !s_q.busy));

    // R6: a waiting access always has a live count
    a_r6_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt != '0));

endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen
    import iow_pkg::*;
#(
    parameter int                    BUS_ADDR_W = 14,
    parameter int                    DATA_W     = 16,
    parameter int                    IO_ADDR_W  = 11,
    parameter logic [BUS_ADDR_W-1:0] CTRL_ADDR  = 14'h3FFE,
    parameter logic [DATA_W-1:0]     RESET_VAL  = 16'h7FFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [BUS_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic                  acc_req,
    input  logic                  acc_io,
    input  logic [BUS_ADDR_W-1:0] acc_addr,
    output logic                  acc_ready,
    output logic                  acc_done
);

    ctrl_t                  ctrl;
    code_t                  code;
    cnt_t                   count;
    logic [NUM_REGIONS-1:0] region_hit;

    iow_ctrl_reg #(
        .BUS_ADDR_W (BUS_ADDR_W),
        .DATA_W     (DATA_W),
        .CTRL_ADDR  (CTRL_ADDR),
        .RESET_VAL  (RESET_VAL)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .ctrl  (ctrl)
    );

    iow_code_sel #(
        .BUS_ADDR_W (BUS_ADDR_W),
        .IO_ADDR_W  (IO_ADDR_W)
    ) u_sel (
        .ctrl       (ctrl),
        .is_io      (acc_io),
        .addr       (acc_addr),
        .code       (code),
        .region_hit (region_hit)
    );

    iow_count_map u_map (
        .code     (code),
        .dbl_mode (ctrl.dbl_mode),
        .count    (count)
    );

    iow_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (acc_req),
        .count (count),
        .ready (acc_ready),
        .done  (acc_done)
    );

    // R5/R6: done is never raised while wait states are still being inserted
    a_r6_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> acc_ready);

endmodule

// File: tb/io_wait_gen_test.sv
module io_wait_gen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [13:0] cfg_addr;
    logic [15:0] cfg_wdata;
    logic        acc_req;
    logic        acc_io;
    logic [13:0] acc_addr;
    logic        acc_ready;
    logic        acc_done;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    io_wait_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_io(acc_io),
        .acc_addr(acc_addr), .acc_ready(acc_ready), .acc_done(acc_done)
    );

    // vector: {io, addr[13:0], ctrl[15:0]}
    localparam int NV = 12;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 14'h0000, 16'h0000},   // R3 code 0 region 0
        {1'b1, 14'h01FF, 16'h0005},   // R2 top of region 0
        {1'b1, 14'h0200, 16'h0030},   // R2 bottom of region 1
        {1'b1, 14'h05FF, 16'h0180},   // R2 top of region 2
        {1'b1, 14'h0600, 16'h0A00},   // R2 region 3
        {1'b1, 14'h3A00, 16'h0038},   // R1 upper bits set, low bits region 1
        {1'b1, 14'h2000, 16'h0E07},   // R1 upper bits, region 0
        {1'b1, 14'h0400, 16'h81C0},   // R4 code 7 doubled -> 15
        {1'b1, 14'h07FF, 16'h8000},   // R4 code 0 doubled -> 1
        {1'b0, 14'h0600, 16'h3000},   // R8 data space code 3
        {1'b0, 14'h0000, 16'hC000},   // R8 data space code 4 doubled -> 9
        {1'b1, 14'h0300, 16'h8010}    // R4 region 1 code 2 doubled -> 5
    };

    function automatic int exp_waits(input logic [15:0] c, input logic io, input logic [13:0] a);
        int code;
        int r;
        r    = int'(a[10:9]);
        code = io ? int'(c[3*r +: 3]) : int'(c[14:12]);
        return c[15] ? 2*code + 1 : code;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [13:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // inject: 0 none, 1 extra strobe mid-wait, 2 control write of zero mid-wait
    task automatic run_access(input logic io, input logic [13:0] a, input int inject,
                              output int waits, output int dones);
        int guard;
        acc_req = 1'b1; acc_io = io; acc_addr = a;
        @(negedge clk);
        acc_req = 1'b0;
        waits = 0; dones = 0; guard = 0;
        while (!acc_done && guard < 40) begin
            if (!acc_ready) waits++;
            if (waits == 2 && inject == 1) acc_req = 1'b1;
            if (waits == 2 && inject == 2) begin
                cfg_we = 1'b1; cfg_addr = 14'h3FFE; cfg_wdata = 16'h0000;
            end
            @(negedge clk);
            acc_req = 1'b0; cfg_we = 1'b0;
            guard++;
        end
        if (acc_done && acc_ready) dones++;
        @(negedge clk);
        if (acc_done) dones++;
    endtask

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int w, d, e;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        acc_req = 1'b0; acc_io = 1'b1; acc_addr = '0;
        repeat (3) @(negedge clk);
        check(acc_ready && !acc_done, "R11 reset outputs", int'({acc_ready, acc_done}), 2);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset word gives 7 waits everywhere
        for (int r = 0; r < 4; r++) begin
            run_access(1'b1, 14'(r * 16'h200), 0, w, d);
            check(w == 7 && d == 1, "R11 reset code region", w, 7);
        end
        run_access(1'b0, 14'h0000, 0, w, d);
        check(w == 7 && d == 1, "R11 reset data code", w, 7);

        // table walk: R1 R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            cfg_write(14'h3FFE, VEC[i][15:0]);
            e = exp_waits(VEC[i][15:0], VEC[i][30], VEC[i][29:16]);
            run_access(VEC[i][30], VEC[i][29:16], 0, w, d);
            check(w == e, "R6 wait count (R2/R3/R4/R8)", w, e);
            check(d == 1, "R6 single done pulse", d, 1);
        end

        // R5: zero wait, done in next cycle with ready high
        cfg_write(14'h3FFE, 16'h0000);
        acc_req = 1'b1; acc_io = 1'b1; acc_addr = 14'h0123;
        @(negedge clk);
        acc_req = 1'b0;
        check(acc_done && acc_ready, "R5 zero-wait completes next cycle", int'({acc_done, acc_ready}), 3);

        // R7: write to a neighbouring address is ignored
        @(negedge clk);
        cfg_write(14'h3FFE, 16'h0006);
        cfg_write(14'h3FFD, 16'h0000);
        cfg_write(14'h3FFF, 16'h0000);
        run_access(1'b1, 14'h0010, 0, w, d);
        check(w == 6, "R7 other address ignored", w, 6);

        // R9: strobe while waiting is ignored
        run_access(1'b1, 14'h0010, 1, w, d);
        check(w == 6 && d == 1, "R9 strobe during wait ignored", w * 10 + d, 61);

        // R10: write during access does not change it, next access uses it
        run_access(1'b1, 14'h0010, 2, w, d);
        check(w == 6, "R10 in-flight access keeps count", w, 6);
        run_access(1'b1, 14'h0010, 0, w, d);
        check(w == 0 && d == 1, "R10 next access uses new word", w, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule